// File: doc/BRIEF.md
# MDIO Management Slave with Optional Preamble

This block is the management-side slave of a physical-layer device. A station manager drives a clock line and a shared data line; the slave decodes read and write frames from that line and gives access to a bank of thirty-two 16-bit registers. Every piece of logic runs on the rising edge of the management clock. The line is modelled as a sampled input, a data output and an output enable. The surrounding pad or bench resolves these into the real open line, which a pull-up holds high when nobody drives it.

The slave does not require the 32-bit run of ones that normally comes before each frame. It watches the line for a 0 followed by a 1. That pattern starts a frame, whether any ones came first or not. Frames that do carry the full run of ones decode in the same way.

Register 1 is a read-only status word whose bit 6 reports that frames without the leading ones are accepted. Registers 2 and 3 hold fixed identification words. All other registers are plain storage.

Top module: `mdio_slave_top`

## Requirements
- R1: After reset `mdio_oe` is 0 and stays 0 while no frame is being decoded. Every writable register reads 0x0000 until it is first written.
- R2: A frame that begins with 32 bits of 1 and is then followed by start bits 0,1 is executed.
- R3: A frame whose start bits 0,1 come with no run of ones before them is executed. This holds directly after reset idle and directly after a previous frame.
- R4: Register 1 always reads 0x7849, so its bit 6 (preamble not required) reads as 1.
- R5: The frame layout is: opcode (10 = read, 01 = write), a 5-bit device address, a 5-bit register address and two turnaround bits, all sent MSB first. In a read, the slave keeps `mdio_oe` at 0 during the first turnaround bit and drives 0 during the second.
- R6: A read returns the 16 register bits MSB first, one per clock, each valid before the rising edge that samples it. `mdio_oe` returns to 0 in the bit period after the last data bit.
- R7: A frame whose device address differs from `phy_addr` changes no register. During such a frame, `mdio_oe` is never asserted.
- R8: A write to any register other than 1, 2 or 3 stores its 16 data bits. Writes to registers 1 to 3 leave their values unchanged.
- R9: A frame with opcode 00 or 11 is consumed as a full 32-bit frame after its start bits. It changes no register and never drives the line.
- R10: Frames sent back to back with no idle bit between them are each decoded correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mdc | input | 1 | Management clock; all state moves on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| phy_addr | input | 5 | Strapped device address that frames must match |
| mdio_in | input | 1 | Resolved level of the data line |
| mdio_out | output | 1 | Value the slave puts on the line while enabled |
| mdio_oe | output | 1 | Output enable of the data line driver |

## Verification
The tightest overlap comes when the last data bit of one frame and the first start bit of the next share a clock boundary. On that edge the slave commits a write or releases the line, and in the same cycle it must re-arm the start-pattern hunt. The bench provokes this by chaining write, write and read frames with no idle bit between them. The read-back then has to return both written words. This shows that neither the commit nor the start detection was lost, and that the read's turnaround timing is unchanged.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int unsigned MDIO_AW = 5;
  localparam int unsigned MDIO_DW = 16;
  localparam int unsigned MDIO_NREG = 32;
  localparam int unsigned PRE_SUP_BIT = 6;

  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;

  typedef enum logic [1:0] {
    S_HUNT,
    S_HEAD,
    S_TURN,
    S_DATA
  } fr_state_e;

  // Header length after the start bits: opcode, device address, register address.
  function automatic int unsigned head_len(input int unsigned aw);
    return 2 + 2 * aw;
  endfunction

  // Registers 1..3 are fixed words that writes cannot change.
  function automatic logic is_ro(input int unsigned a);
    return (a >= 1) && (a <= 3);
  endfunction

  // Status word with the preamble-not-required flag forced on.
  function automatic logic [MDIO_DW-1:0] status_word(input logic [MDIO_DW-1:0] base);
    logic [MDIO_DW-1:0] w;
    w = base;
    w[PRE_SUP_BIT] = 1'b1;
    return w;
  endfunction

endpackage

// File: rtl/mdio_frame_rx.sv
module mdio_frame_rx #(
  parameter int unsigned AW = mdio_pkg::MDIO_AW,
  parameter int unsigned DW = mdio_pkg::MDIO_DW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mdio_in,
  input  logic [AW-1:0]       phy_addr,
  output mdio_pkg::fr_state_e state_o,
  output logic [AW-1:0]       reg_addr,
  output logic                wr_en,
  output logic [DW-1:0]       wr_data,
  output logic                rd_load,
  output logic                rd_shift,
  output logic                rd_release,
  output logic                rd_active
);
  import mdio_pkg::*;

  localparam int unsigned HEAD_W = head_len(AW);
  localparam int unsigned CNT_MAX = (DW > HEAD_W) ? DW : HEAD_W;
  localparam int unsigned CNT_W = $clog2(CNT_MAX);
  localparam logic [CNT_W-1:0] HEAD_LAST = CNT_W'(HEAD_W - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DW - 1);
  localparam logic [CNT_W-1:0] TURN_LAST = CNT_W'(1);

  fr_state_e          state;
  logic [CNT_W-1:0]   cnt;
  logic               prev_q;
  logic [HEAD_W-2:0]  head_q;
  logic [DW-2:0]      data_q;
  logic               rd_q;
  logic               wr_q;
  logic [AW-1:0]      addr_q;

  // Named internal events
  logic               sof_seen;
  logic               head_done;
  logic               data_done;
  logic [HEAD_W-1:0]  head_nx;
  logic [1:0]         op_nx;
  logic [AW-1:0]      phy_nx;
  logic [AW-1:0]      ra_nx;
  logic               addr_match;

  assign sof_seen   = (state == S_HUNT) && !prev_q && mdio_in;
  assign head_done  = (state == S_HEAD) && (cnt == HEAD_LAST);
  assign data_done  = (state == S_DATA) && (cnt == DATA_LAST);
  assign head_nx    = {head_q, mdio_in};
  assign op_nx      = head_nx[HEAD_W-1 -: 2];
  assign phy_nx     = head_nx[2*AW-1 -: AW];
  assign ra_nx      = head_nx[AW-1:0];
  assign addr_match = (phy_nx == phy_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_HUNT;
      cnt    <= '0;
      prev_q <= 1'b1;
      head_q <= '0;
      data_q <= '0;
      rd_q   <= 1'b0;
      wr_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      case (state)
        S_HUNT: begin
          prev_q <= mdio_in;
          if (sof_seen) begin
            state <= S_HEAD;
            cnt   <= '0;
          end
        end
        S_HEAD: begin
          head_q <= head_nx[HEAD_W-2:0];
          cnt    <= cnt + 1'b1;
          if (head_done) begin
            state  <= S_TURN;
            cnt    <= '0;
            rd_q   <= addr_match && (op_nx == OP_READ);
            wr_q   <= addr_match && (op_nx == OP_WRITE);
            addr_q <= ra_nx;
          end
        end
        S_TURN: begin
          cnt <= cnt + 1'b1;
          if (cnt == TURN_LAST) begin
            state <= S_DATA;
            cnt   <= '0;
          end
        end
        S_DATA: begin
          data_q <= {data_q[DW-3:0], mdio_in};
          cnt    <= cnt + 1'b1;
          if (data_done) begin
            state  <= S_HUNT;
            cnt    <= '0;
            prev_q <= 1'b1;
            rd_q   <= 1'b0;
            wr_q   <= 1'b0;
          end
        end
        default: state <= S_HUNT;
      endcase
    end
  end

  assign state_o    = state;
  assign reg_addr   = addr_q;
  assign rd_active  = rd_q;
  assign wr_en      = wr_q && data_done;
  assign wr_data    = {data_q, mdio_in};
  assign rd_load    = rd_q && (state == S_TURN) && (cnt == '0);
  assign rd_shift   = rd_q && (((state == S_TURN) && (cnt == TURN_LAST)) ||
                               ((state == S_DATA) && (cnt != DATA_LAST)));
  assign rd_release = rd_q && data_done;

  // Every frame is exactly DW data bits long and then hunting resumes (back to back).
  assert_frame_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    data_done |=> (state == S_HUNT));

  // A completed header always leads into the turnaround.
  assert_head_to_turn_R5: assert property (@(posedge clk) disable iff (!rst_n)
    head_done |=> (state == S_TURN) && (cnt == '0));

endmodule

// File: rtl/mdio_regs.sv
module mdio_regs #(
  parameter int unsigned AW          = mdio_pkg::MDIO_AW,
  parameter int unsigned DW          = mdio_pkg::MDIO_DW,
  parameter int unsigned NREG        = mdio_pkg::MDIO_NREG,
  parameter logic [DW-1:0] STATUS_BASE = 16'h7809,
  parameter logic [DW-1:0] ID_HI     = 16'hA5C3,
  parameter logic [DW-1:0] ID_LO     = 16'h5E10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data
);
  import mdio_pkg::*;

  function automatic logic [DW-1:0] fixed_word(input int unsigned a);
    case (a)
      1:       return status_word(STATUS_BASE);
      2:       return ID_HI;
      3:       return ID_LO;
      default: return '0;
    endcase
  endfunction

  logic [DW-1:0] word [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (is_ro(i)) begin : g_fixed
      assign word[i] = fixed_word(i);
    end else begin : g_store
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          word[i] <= '0;
        end else if (wr_en && (addr == AW'(i))) begin
          word[i] <= wr_data;
        end
      end
    end
  end

  assign rd_data = word[addr];

  // Writes to storage registers land with the full data word.
  assert_write_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !is_ro(int'(addr))) |=> (word[$past(addr)] == $past(wr_data)));

  // Register 1 keeps its supported-flag set at all times.
  assert_status_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == AW'(1)) |-> rd_data[PRE_SUP_BIT]);

endmodule

// File: rtl/mdio_out_drv.sv
module mdio_out_drv #(
  parameter int unsigned DW = mdio_pkg::MDIO_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          shift,
  input  logic          release_line,
  input  logic [DW-1:0] load_data,
  output logic          mdio_out,
  output logic          mdio_oe
);

  logic [DW-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q     <= '0;
      mdio_out <= 1'b0;
      mdio_oe  <= 1'b0;
    end else if (load) begin
      sh_q     <= load_data;
      mdio_out <= 1'b0;
      mdio_oe  <= 1'b1;
    end else if (shift) begin
      mdio_out <= sh_q[DW-1];
      sh_q     <= {sh_q[DW-2:0], 1'b0};
    end else if (release_line) begin
      mdio_oe  <= 1'b0;
      mdio_out <= 1'b0;
    end
  end

  // Second turnaround bit is a driven zero.
  assert_turn_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (mdio_oe && !mdio_out));

  // Line let go right after the final data bit.
  assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    release_line |=> !mdio_oe);

  // While shifting data the driver stays enabled.
  assert_shift_driven_R6: assert property (@(posedge clk) disable iff (!rst_n)
    shift |-> mdio_oe);

endmodule

// File: rtl/mdio_slave_top.sv
module mdio_slave_top #(
  parameter int unsigned AW          = mdio_pkg::MDIO_AW,
  parameter int unsigned DW          = mdio_pkg::MDIO_DW,
  parameter int unsigned NREG        = mdio_pkg::MDIO_NREG,
  parameter logic [DW-1:0] STATUS_BASE = 16'h7809,
  parameter logic [DW-1:0] ID_HI     = 16'hA5C3,
  parameter logic [DW-1:0] ID_LO     = 16'h5E10
) (
  input  logic          mdc,
  input  logic          rst_n,
  input  logic [AW-1:0] phy_addr,
  input  logic          mdio_in,
  output logic          mdio_out,
  output logic          mdio_oe
);
  import mdio_pkg::*;

  fr_state_e     fr_state;
  logic [AW-1:0] reg_addr;
  logic          wr_en;
  logic [DW-1:0] wr_data;
  logic [DW-1:0] rd_data;
  logic          rd_load;
  logic          rd_shift;
  logic          rd_release;
  logic          rd_active;

  mdio_frame_rx #(.AW(AW), .DW(DW)) u_rx (
    .clk        (mdc),
    .rst_n      (rst_n),
    .mdio_in    (mdio_in),
    .phy_addr   (phy_addr),
    .state_o    (fr_state),
    .reg_addr   (reg_addr),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_load    (rd_load),
    .rd_shift   (rd_shift),
    .rd_release (rd_release),
    .rd_active  (rd_active)
  );

  mdio_regs #(
    .AW(AW), .DW(DW), .NREG(NREG),
    .STATUS_BASE(STATUS_BASE), .ID_HI(ID_HI), .ID_LO(ID_LO)
  ) u_regs (
    .clk     (mdc),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (reg_addr),
    .wr_data (wr_data),
    .rd_data (rd_data)
  );

  mdio_out_drv #(.DW(DW)) u_drv (
    .clk          (mdc),
    .rst_n        (rst_n),
    .load         (rd_load),
    .shift        (rd_shift),
    .release_line (rd_release),
    .load_data    (rd_data),
    .mdio_out     (mdio_out),
    .mdio_oe      (mdio_oe)
  );

  // Driver only on for a matched read frame.
  assert_drive_only_read_R7: assert property (@(posedge mdc) disable iff (!rst_n)
    mdio_oe |-> rd_active);

  // Never driving while hunting for a start pattern.
  assert_hunt_quiet_R1: assert property (@(posedge mdc) disable iff (!rst_n)
    (fr_state == S_HUNT) |-> !mdio_oe);

  // Reads and writes never coincide.
  assert_no_rw_clash_R9: assert property (@(posedge mdc) disable iff (!rst_n)
    !(wr_en && (rd_load || rd_shift)));

endmodule

// File: tb/sim_mdio_slave_top.sv
module sim_mdio_slave_top;

  localparam int CLK_PERIOD = 100;
  localparam logic [4:0] MY_PHY = 5'h0B;
  localparam logic [4:0] OTHER_PHY = 5'h0C;

  logic mdc = 1'b0;
  logic rst_n = 1'b0;
  logic m_oe = 1'b1;
  logic m_val = 1'b1;
  logic s_out;
  logic s_oe;
  logic line;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) mdc = ~mdc;

  assign line = s_oe ? s_out : (m_oe ? m_val : 1'b1);

  mdio_slave_top u0 (
    .mdc      (mdc),
    .rst_n    (rst_n),
    .phy_addr (MY_PHY),
    .mdio_in  (line),
    .mdio_out (s_out),
    .mdio_oe  (s_oe)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive_bit(input logic b);
    @(negedge mdc);
    m_oe  = 1'b1;
    m_val = b;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive_bit(1'b1);
  endtask

  task automatic send_head(input bit pre, input logic [1:0] op,
                           input logic [4:0] phy, input logic [4:0] ra);
    if (pre) for (int i = 0; i < 32; i++) drive_bit(1'b1);
    drive_bit(1'b0);
    drive_bit(1'b1);
    for (int i = 1; i >= 0; i--) drive_bit(op[i]);
    for (int i = 4; i >= 0; i--) drive_bit(phy[i]);
    for (int i = 4; i >= 0; i--) drive_bit(ra[i]);
  endtask

  task automatic do_write(input bit pre, input logic [4:0] phy,
                          input logic [4:0] ra, input logic [15:0] d);
    send_head(pre, 2'b01, phy, ra);
    drive_bit(1'b1);
    drive_bit(1'b0);
    for (int i = 15; i >= 0; i--) drive_bit(d[i]);
  endtask

  task automatic do_raw(input logic [1:0] op, input logic [4:0] ra, input logic [15:0] d);
    send_head(1'b0, op, MY_PHY, ra);
    drive_bit(1'b1);
    drive_bit(1'b0);
    for (int i = 15; i >= 0; i--) drive_bit(d[i]);
  endtask

  task automatic do_read(input bit pre, input logic [4:0] phy, input logic [4:0] ra,
                         output logic [15:0] d, output logic ta1, output logic ta2,
                         output logic rel, output logic drove);
    send_head(pre, 2'b10, phy, ra);
    drove = 1'b0;
    d = '0;
    @(negedge mdc);
    m_oe = 1'b0;
    ta1 = !s_oe;
    drove |= s_oe;
    @(negedge mdc);
    ta2 = s_oe && !s_out;
    drove |= s_oe;
    for (int i = 0; i < 16; i++) begin
      @(negedge mdc);
      d = {d[14:0], line};
      drove |= s_oe;
    end
    @(negedge mdc);
    rel = !s_oe;
    m_oe = 1'b1;
    m_val = 1'b1;
  endtask

  task automatic rd_simple(input bit pre, input logic [4:0] ra, output logic [15:0] d);
    logic a, b, c, e;
    do_read(pre, MY_PHY, ra, d, a, b, c, e);
  endtask

  task automatic t_reset;
    logic [15:0] d;
    chk("R1 oe after reset", {15'd0, s_oe}, 16'h0000);
    idle(4);
    chk("R1 oe idle", {15'd0, s_oe}, 16'h0000);
    rd_simple(1'b1, 5'd9, d);
    chk("R1 reg9 reset value", d, 16'h0000);
  endtask

  task automatic t_status_preamble;
    logic [15:0] d;
    logic a, b, c, e;
    do_read(1'b1, MY_PHY, 5'd1, d, a, b, c, e);
    chk("R2 status read with preamble", d, 16'h7849);
    chk("R4 status bit6", {15'd0, d[6]}, 16'h0001);
    chk("R5 turnaround bit1 released", {15'd0, a}, 16'h0001);
    chk("R5 turnaround bit2 driven zero", {15'd0, b}, 16'h0001);
    chk("R6 line released after data", {15'd0, c}, 16'h0001);
  endtask

  task automatic t_no_preamble;
    logic [15:0] d;
    idle(3);
    rd_simple(1'b0, 5'd2, d);
    chk("R3 id hi read without preamble", d, 16'hA5C3);
    rd_simple(1'b0, 5'd3, d);
    chk("R3 id lo read without preamble", d, 16'h5E10);
  endtask

  task automatic t_write_read;
    logic [15:0] d;
    do_write(1'b0, MY_PHY, 5'd5, 16'hBEEF);
    idle(2);
    rd_simple(1'b1, 5'd5, d);
    chk("R8 R3 write no preamble readback", d, 16'hBEEF);
    do_write(1'b1, MY_PHY, 5'd31, 16'h0F0F);
    rd_simple(1'b0, 5'd31, d);
    chk("R2 R8 write with preamble readback", d, 16'h0F0F);
  endtask

  task automatic t_ro_ignore;
    logic [15:0] d;
    do_write(1'b0, MY_PHY, 5'd1, 16'h0000);
    do_write(1'b0, MY_PHY, 5'd2, 16'h1111);
    rd_simple(1'b0, 5'd1, d);
    chk("R8 R4 status unchanged by write", d, 16'h7849);
    rd_simple(1'b0, 5'd2, d);
    chk("R8 id hi unchanged by write", d, 16'hA5C3);
  endtask

  task automatic t_mismatch;
    logic [15:0] d;
    logic a, b, c, e;
    do_write(1'b0, OTHER_PHY, 5'd0, 16'hDEAD);
    idle(1);
    do_read(1'b0, OTHER_PHY, 5'd1, d, a, b, c, e);
    chk("R7 foreign read never drives", {15'd0, e}, 16'h0000);
    chk("R7 foreign read sees pull-up", d, 16'hFFFF);
    rd_simple(1'b0, 5'd0, d);
    chk("R7 foreign write ignored", d, 16'h0000);
  endtask

  task automatic t_bad_op;
    logic [15:0] d;
    logic saw;
    saw = 1'b0;
    fork
      begin
        do_raw(2'b11, 5'd6, 16'h1234);
        do_raw(2'b00, 5'd6, 16'h5678);
      end
      begin
        for (int i = 0; i < 64; i++) begin
          @(negedge mdc);
          saw |= s_oe;
        end
      end
    join
    chk("R9 invalid opcode never drives", {15'd0, saw}, 16'h0000);
    rd_simple(1'b0, 5'd6, d);
    chk("R9 invalid opcode no write", d, 16'h0000);
  endtask

  task automatic t_back_to_back;
    logic [15:0] d;
    logic a, b, c, e;
    do_write(1'b0, MY_PHY, 5'd7, 16'h1357);
    do_write(1'b0, MY_PHY, 5'd8, 16'h2468);
    do_read(1'b0, MY_PHY, 5'd7, d, a, b, c, e);
    chk("R10 first of chained writes", d, 16'h1357);
    chk("R10 R5 chained read turnaround", {14'd0, a, b}, 16'h0003);
    rd_simple(1'b0, 5'd8, d);
    chk("R10 second of chained writes", d, 16'h2468);
  endtask

  task automatic t_msb;
    logic [15:0] d;
    do_write(1'b0, MY_PHY, 5'd10, 16'h8001);
    rd_simple(1'b0, 5'd10, d);
    chk("R6 msb first ordering", d, 16'h8001);
    do_write(1'b0, MY_PHY, 5'd10, 16'h4C02);
    rd_simple(1'b1, 5'd10, d);
    chk("R6 second pattern", d, 16'h4C02);
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge mdc);
    rst_n = 1'b1;
    @(negedge mdc);
    t_reset();
    t_status_preamble();
    t_no_preamble();
    t_write_read();
    t_ro_ignore();
    t_mismatch();
    t_bad_op();
    t_back_to_back();
    t_msb();
    idle(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge mdc) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog R1 actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule